// File: doc/BRIEF.md
# Multi-Frame SPI ADC Burst Sequencer

This block is an SPI master that samples a multi-channel ADC in bursts. Software programs the frame shape, the SCLK divider, the number of frames and the idle gap between frames through a small register file. It then loads a transmit word and issues a start command. From that point the sequencer runs every frame of the burst without further help. In each frame it lowers chip select, shifts the transmit word out and shifts the reply in. It stores each reply in a result slot indexed by frame number and then waits out the gap before the next frame.

A status register reports a busy flag and two sticky error flags. Software polls the busy flag until the burst ends, then reads the result slots. The number of bits driven and the number of bits captured are set apart from the frame length. A frame can therefore send a short command and capture a wider reply, or the reverse. A transmit word of all zeros keeps MOSI low for the whole frame. A converter uses this to repeat its previous command.

Register map (write port `reg_addr`, read port `reg_rd_addr`): 0 frame shape, 1 timing, 2 gap, 3 transmit word, 4 command (write only), 5 status (read only). Other read addresses return zero.

Top module: `adc_burst_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0 and `spi_mosi` is 0. Status (address 5) reads 0 and every result slot reads 0.
- R2: A write of 1 to bit 31 of address 4 starts a burst when the sequencer is idle and the configuration is valid. The burst runs exactly the programmed number of frames: address 1 bits [23:16], counted from 1. `spi_cs_n` is low during each frame and high otherwise. `spi_sclk` is low whenever `spi_cs_n` is high.
- R3: Each frame carries exactly as many SCLK rising edges as the frame length (address 0 bits [7:0]). Every SCLK half period inside a frame, including the first low phase after chip select falls, lasts divider+1 clock cycles. The divider is address 1 bits [DIV_W-1:0].
- R4: MOSI carries the low `out` bits of the transmit word (address 3), MSB first. `out` is address 0 bits [15:8]. MOSI is 0 for the remaining bits of the frame. MOSI changes only while SCLK is low, so it is stable across each rising edge and the high phase. An all-zero word gives a constant 0.
- R5: MISO is sampled on the SCLK rising edges of the first `in` bits of each frame, where `in` is address 0 bits [23:16]. The stored word holds these bits right-aligned, first bit most significant, with zeros above.
- R6: The word of frame k, counted from 0, is stored in result slot k and read on `res_word` when `res_sel` = k.
- R7: Between two frames of one burst, `spi_cs_n` stays high for exactly gap+1 clock cycles. The gap is address 2 bits [GAP_W-1:0].
- R8: Status bit 0 (busy) is 1 from the clock edge that accepts a start. It stays 1 until the edge that stores the last frame's word. The last word is readable in the same cycle that busy first reads 0.
- R9: A start written while busy is ignored: the running burst still runs exactly its programmed frame count. Such a start sets status bit 1.
- R10: A start is rejected if the configuration is invalid. The configuration is invalid when any of these hold:
  - the frame count is 0 or greater than MAX_FRAMES;
  - the frame length is 0 or greater than DATA_W;
  - `out` or `in` exceeds the frame length.

  A rejected start sets status bit 2. Busy stays 0 and `spi_cs_n` stays high.
- R11: Status bits 1 and 2 are sticky. Only an accepted start clears them.
- R12: Addresses 0 to 3 read back the full 32-bit word last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_rd_addr | input | 3 | Read address |
| reg_rdata | output | 32 | Read data for `reg_rd_addr` (combinational) |
| res_sel | input | IDX_W | Result slot select |
| res_word | output | DATA_W | Stored word of the selected slot |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the ADC |
| spi_miso | input | 1 | Serial data from the ADC |

## Verification
The bench keeps DATA_W=16 and MAX_FRAMES=16, and narrows DIV_W to 4 and GAP_W to 6. This makes a full 16-frame burst reachable, which writes every result slot and the highest frame index. It also covers a full 16-bit frame, the minimum divider and zero gap, and the rejection of a frame count one above MAX_FRAMES. A bus-functional ADC model answers each frame with a different word. This exposes any frame-to-slot mixing and any mismatch between the out, in and frame bit counts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int REG_W = 32;
    localparam int FLD_W = 8;
    localparam int ADR_W = 3;

    localparam logic [ADR_W-1:0] A_SHAPE  = 3'd0;
    localparam logic [ADR_W-1:0] A_TIMING = 3'd1;
    localparam logic [ADR_W-1:0] A_GAP    = 3'd2;
    localparam logic [ADR_W-1:0] A_TXW    = 3'd3;
    localparam logic [ADR_W-1:0] A_CMD    = 3'd4;
    localparam logic [ADR_W-1:0] A_STAT   = 3'd5;

    localparam int CMD_GO_BIT  = 31;
    localparam int ST_BUSY     = 0;
    localparam int ST_COLL     = 1;
    localparam int ST_BADCFG   = 2;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FRAME = 2'd1,
        S_GAP   = 2'd2
    } seq_st_e;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int MAX_FRAMES = 16,
    parameter int DIV_W      = 8,
    parameter int GAP_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [ADR_W-1:0]  reg_rd_addr,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    output logic              go,
    output logic              err_coll,
    output logic              err_cfg,
    output logic [FLD_W-1:0]  frame_bits,
    output logic [FLD_W-1:0]  out_bits,
    output logic [FLD_W-1:0]  in_bits,
    output logic [FLD_W-1:0]  frames,
    output logic [DIV_W-1:0]  div,
    output logic [GAP_W-1:0]  gap,
    output logic [DATA_W-1:0] tx_word
);
    typedef struct packed {
        logic [REG_W-1:0] shape;
        logic [REG_W-1:0] timing;
        logic [REG_W-1:0] gap;
        logic [REG_W-1:0] txw;
        logic             err_coll;
        logic             err_cfg;
    } regs_t;

    regs_t q, d;
    logic  start_wr, cfg_ok;

    assign frame_bits = q.shape[FLD_W-1:0];
    assign out_bits   = q.shape[2*FLD_W-1:FLD_W];
    assign in_bits    = q.shape[3*FLD_W-1:2*FLD_W];
    assign frames     = q.timing[3*FLD_W-1:2*FLD_W];
    assign div        = q.timing[DIV_W-1:0];
    assign gap        = q.gap[GAP_W-1:0];
    assign tx_word    = q.txw[DATA_W-1:0];
    assign err_coll   = q.err_coll;
    assign err_cfg    = q.err_cfg;

    always_comb begin
        d        = q;
        start_wr = reg_wr && (reg_addr == A_CMD) && reg_wdata[CMD_GO_BIT];
        cfg_ok   = (frames != '0) && (frames <= FLD_W'(MAX_FRAMES)) &&
                   (frame_bits != '0) && (frame_bits <= FLD_W'(DATA_W)) &&
                   (out_bits <= frame_bits) && (in_bits <= frame_bits);
        go       = start_wr && !busy && cfg_ok;
        if (reg_wr) begin
            case (reg_addr)
                A_SHAPE:  d.shape  = reg_wdata;
                A_TIMING: d.timing = reg_wdata;
                A_GAP:    d.gap    = reg_wdata;
                A_TXW:    d.txw    = reg_wdata;
                default:  ;
            endcase
        end
        if (start_wr) begin
            if (busy) begin
                d.err_coll = 1'b1;
            end else if (!cfg_ok) begin
                d.err_cfg = 1'b1;
            end else begin
                d.err_coll = 1'b0;
                d.err_cfg  = 1'b0;
            end
        end
        case (reg_rd_addr)
            A_SHAPE:  reg_rdata = q.shape;
            A_TIMING: reg_rdata = q.timing;
            A_GAP:    reg_rdata = q.gap;
            A_TXW:    reg_rdata = q.txw;
            A_STAT: begin
                reg_rdata             = '0;
                reg_rdata[ST_BUSY]    = busy;
                reg_rdata[ST_COLL]    = q.err_coll;
                reg_rdata[ST_BADCFG]  = q.err_cfg;
            end
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
    import adc_seq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int MAX_FRAMES = 16,
    parameter int DIV_W      = 8,
    parameter int GAP_W      = 12,
    localparam int IDX_W     = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [FLD_W-1:0]  frame_bits,
    input  logic [FLD_W-1:0]  out_bits,
    input  logic [FLD_W-1:0]  in_bits,
    input  logic [FLD_W-1:0]  frames,
    input  logic [DIV_W-1:0]  div,
    input  logic [GAP_W-1:0]  gap,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    output logic              busy,
    output logic              res_we,
    output logic [IDX_W-1:0]  res_idx,
    output logic [DATA_W-1:0] res_data
);
    typedef struct packed {
        seq_st_e           st;
        logic [DIV_W-1:0]  hc;
        logic [FLD_W-1:0]  bit_idx;
        logic [FLD_W-1:0]  frame_idx;
        logic [GAP_W-1:0]  gap_cnt;
        logic [DATA_W-1:0] shreg;
        logic              sclk;
        logic              cs_n;
        logic              mosi;
    } eng_t;

    eng_t q, d;

    function automatic logic tx_bit(input logic [FLD_W-1:0] pos);
        logic [DATA_W-1:0] shifted;
        shifted = tx_word >> (out_bits - pos - FLD_W'(1));
        return (pos < out_bits) ? shifted[0] : 1'b0;
    endfunction

    assign sclk    = q.sclk;
    assign cs_n    = q.cs_n;
    assign mosi    = q.mosi;
    assign busy    = (q.st != S_IDLE);
    assign res_idx = q.frame_idx[IDX_W-1:0];

    always_comb begin
        d        = q;
        res_we   = 1'b0;
        res_data = q.shreg;
        case (q.st)
            S_IDLE: begin
                if (go) begin
                    d.st        = S_FRAME;
                    d.cs_n      = 1'b0;
                    d.sclk      = 1'b0;
                    d.hc        = '0;
                    d.bit_idx   = '0;
                    d.frame_idx = '0;
                    d.shreg     = '0;
                    d.mosi      = tx_bit('0);
                end
            end
            S_FRAME: begin
                if (q.hc == div) begin
                    d.hc = '0;
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                        if (q.bit_idx < in_bits)
                            d.shreg = {q.shreg[DATA_W-2:0], miso};
                    end else begin
                        d.sclk = 1'b0;
                        if (q.bit_idx == frame_bits - FLD_W'(1)) begin
                            res_we  = 1'b1;
                            d.cs_n  = 1'b1;
                            d.mosi  = 1'b0;
                            d.gap_cnt = '0;
                            d.st    = (q.frame_idx == frames - FLD_W'(1)) ? S_IDLE : S_GAP;
                        end else begin
                            d.bit_idx = q.bit_idx + FLD_W'(1);
                            d.mosi    = tx_bit(q.bit_idx + FLD_W'(1));
                        end
                    end
                end else begin
                    d.hc = q.hc + DIV_W'(1);
                end
            end
            S_GAP: begin
                if (q.gap_cnt == gap) begin
                    d.st        = S_FRAME;
                    d.cs_n      = 1'b0;
                    d.hc        = '0;
                    d.bit_idx   = '0;
                    d.frame_idx = q.frame_idx + FLD_W'(1);
                    d.shreg     = '0;
                    d.mosi      = tx_bit('0);
                end else begin
                    d.gap_cnt = q.gap_cnt + GAP_W'(1);
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
    parameter int DATA_W     = 16,
    parameter int MAX_FRAMES = 16,
    localparam int IDX_W     = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [MAX_FRAMES-1:0][DATA_W-1:0] slot_q, slot_d;

    always_comb begin
        slot_d = slot_q;
        for (int k = 0; k < MAX_FRAMES; k++) begin
            if (we && (wr_idx == IDX_W'(k))) slot_d[k] = wr_data;
        end
        rd_data = '0;
        for (int k = 0; k < MAX_FRAMES; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = slot_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end
endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int MAX_FRAMES = 16,
    parameter int DIV_W      = 8,
    parameter int GAP_W      = 12,
    localparam int IDX_W     = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [2:0]        reg_rd_addr,
    output logic [31:0]       reg_rdata,
    input  logic [IDX_W-1:0]  res_sel,
    output logic [DATA_W-1:0] res_word,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic              busy, go, err_coll, err_cfg, res_we;
    logic [FLD_W-1:0]  frame_bits, out_bits, in_bits, frames;
    logic [DIV_W-1:0]  div;
    logic [GAP_W-1:0]  gap;
    logic [DATA_W-1:0] tx_word, res_data;
    logic [IDX_W-1:0]  res_idx;

    adc_seq_regs #(
        .DATA_W(DATA_W), .MAX_FRAMES(MAX_FRAMES), .DIV_W(DIV_W), .GAP_W(GAP_W)
    ) u_regs (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rd_addr, .reg_rdata,
        .busy, .go, .err_coll, .err_cfg, .frame_bits, .out_bits, .in_bits,
        .frames, .div, .gap, .tx_word
    );

    adc_seq_engine #(
        .DATA_W(DATA_W), .MAX_FRAMES(MAX_FRAMES), .DIV_W(DIV_W), .GAP_W(GAP_W)
    ) u_engine (
        .clk, .rst_n, .go, .frame_bits, .out_bits, .in_bits, .frames, .div,
        .gap, .tx_word, .miso(spi_miso), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .busy, .res_we, .res_idx, .res_data
    );

    adc_seq_results #(
        .DATA_W(DATA_W), .MAX_FRAMES(MAX_FRAMES)
    ) u_results (
        .clk, .rst_n, .we(res_we), .wr_idx(res_idx), .wr_data(res_data),
        .rd_idx(res_sel), .rd_data(res_word)
    );
endmodule

// File: rtl/adc_burst_seq_chk.sv
module adc_burst_seq_chk
    import adc_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        busy,
    input logic        err_coll,
    input logic        err_cfg,
    input logic        spi_sclk,
    input logic        spi_cs_n,
    input logic        spi_mosi
);
    logic start_wr;
    assign start_wr = reg_wr && (reg_addr == A_CMD) && reg_wdata[CMD_GO_BIT];

    // R2: SCLK rests low whenever chip select is released
    p_sclk_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R2: the SPI lines stay quiet outside a burst
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    // R4: MOSI holds still through the rising edge and the high phase
    p_mosi_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_mosi));

    // R8: a burst begins only from a start command
    p_busy_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_wr));

    // R9: a start while busy raises the collision flag
    p_collision_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && busy) |=> err_coll);

    // R10: a configuration error never coincides with a new burst
    p_badcfg_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_cfg) |-> !busy);
endmodule

bind adc_burst_seq adc_burst_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .err_coll(err_coll), .err_cfg(err_cfg),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/test_adc_burst_seq.sv
`timescale 1ns/1ps
module test_adc_burst_seq;
    localparam int DW = 16, MF = 16, DVW = 4, GPW = 6, IW = 4;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0, reg_rd_addr = 3'd5;
    logic [31:0]   reg_wdata = '0, reg_rdata;
    logic [IW-1:0] res_sel = '0;
    logic [DW-1:0] res_word;
    logic          spi_sclk, spi_cs_n, spi_mosi, spi_miso = 1'b0;

    always #2.5 clk = ~clk;

    adc_burst_seq #(.DATA_W(DW), .MAX_FRAMES(MF), .DIV_W(DVW), .GAP_W(GPW)) i_adc_burst_seq (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rd_addr, .reg_rdata,
        .res_sel, .res_word, .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso
    );

    int total = 0, bad = 0;
    int cur_fb = 1, cur_div = 0, cur_gap = 0, slave_n = 0, seen = 0;
    int unsigned exp_mosi_q[$];
    int unsigned exp_rx[MF];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int unsigned msk(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    endfunction

    function automatic int unsigned sword(input int n);
        return (32'h9C35 + n * 32'h0B17) & 32'hFFFF;
    endfunction

    // Monitor and ADC model: scoreboard side
    int unsigned cap = 0;
    int rises = 0, hp = 0, gcnt = 0, bitn = 0;
    bit hp_bad = 0, prev_cs = 1, prev_sclk = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs = 1; prev_sclk = 0;
        end else begin
            if (prev_cs && !spi_cs_n) begin
                if (seen > 0) chk(gcnt == cur_gap + 1, "R7", "gap cycles", gcnt, cur_gap + 1);
                cap = 0; rises = 0; hp = 1; hp_bad = 0; bitn = 0;
                spi_miso = ((sword(slave_n) >> (cur_fb - 1)) & 1) != 0;
            end else if (!spi_cs_n) begin
                if (spi_sclk != prev_sclk) begin
                    if (hp != cur_div + 1) hp_bad = 1;
                    hp = 1;
                    if (spi_sclk) begin
                        cap = (cap << 1) | 32'(spi_mosi);
                        rises++;
                    end else begin
                        bitn++;
                        spi_miso = (bitn < cur_fb) ?
                            (((sword(slave_n) >> (cur_fb - 1 - bitn)) & 1) != 0) : 1'b0;
                    end
                end else begin
                    hp++;
                end
            end else if (!prev_cs && spi_cs_n) begin
                if (exp_mosi_q.size() == 0) begin
                    chk(0, "R2", "frame beyond programmed count", seen + 1, seen);
                end else begin
                    int unsigned e;
                    e = exp_mosi_q.pop_front();
                    chk((cap & msk(cur_fb)) == e, "R4", "mosi word", cap & msk(cur_fb), e);
                end
                chk(rises == cur_fb, "R3", "sclk rises per frame", rises, cur_fb);
                chk(!hp_bad, "R3", "half period", hp_bad, 0);
                seen++; slave_n++; gcnt = 1; spi_miso = 1'b0;
            end else if (spi_cs_n) begin
                gcnt++;
            end
            prev_cs = spi_cs_n; prev_sclk = spi_sclk;
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic program_cfg(input int fb, input int ob, input int ib, input int dv,
                               input int nfr, input int gp, input logic [31:0] tx);
        reg_write(3'd0, {8'h00, 8'(ib), 8'(ob), 8'(fb)});
        reg_write(3'd1, {8'h00, 8'(nfr), 8'h00, 8'(dv)});
        reg_write(3'd2, 32'(gp));
        reg_write(3'd3, tx);
    endtask

    // Driver: pushes the expected frames, then issues the start
    task automatic start_burst(input int fb, input int ob, input int ib, input int dv,
                               input int nfr, input int gp, input logic [31:0] tx);
        program_cfg(fb, ob, ib, dv, nfr, gp, tx);
        cur_fb = fb; cur_div = dv; cur_gap = gp; slave_n = 0; seen = 0;
        for (int k = 0; k < nfr; k++) begin
            exp_mosi_q.push_back(((tx & msk(ob)) << (fb - ob)) & msk(fb));
            exp_rx[k] = (sword(k) & msk(fb)) >> (fb - ib);
        end
        reg_rd_addr = 3'd5;
        reg_write(3'd4, 32'h8000_0000);
        chk(reg_rdata[0] == 1'b1, "R8", "busy after start", reg_rdata[0], 1);
    endtask

    task automatic finish_burst(input int nfr);
        int waited = 0;
        reg_rd_addr = 3'd5;
        res_sel = IW'(nfr - 1);
        while (reg_rdata[0] && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk(res_word == exp_rx[nfr-1], "R8", "last word with busy low", res_word, exp_rx[nfr-1]);
        for (int k = 0; k < nfr; k++) begin
            res_sel = IW'(k);
            #0.1;
            chk(res_word == exp_rx[k], "R6", $sformatf("slot %0d (R5 capture)", k), res_word, exp_rx[k]);
        end
        chk(seen == nfr, "R2", "frames per burst", seen, nfr);
        chk(exp_mosi_q.size() == 0, "R2", "pending frames", exp_mosi_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", "run did not finish", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0, "R1", "spi lines",
            {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
        chk(reg_rdata == 0, "R1", "status", reg_rdata, 0);
        chk(res_word == 0, "R1", "slot 0", res_word, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: readback of configuration words
        program_cfg(16, 16, 16, 1, 4, 5, 32'hDEAD_A5C3);
        reg_rd_addr = 3'd0; #0.1;
        chk(reg_rdata == 32'h0010_1010, "R12", "shape readback", reg_rdata, 32'h0010_1010);
        reg_rd_addr = 3'd1; #0.1;
        chk(reg_rdata == 32'h0004_0001, "R12", "timing readback", reg_rdata, 32'h0004_0001);
        reg_rd_addr = 3'd3; #0.1;
        chk(reg_rdata == 32'hDEAD_A5C3, "R12", "tx readback", reg_rdata, 32'hDEAD_A5C3);

        // Full-width frames, divider 1, gap 5
        start_burst(16, 16, 16, 1, 4, 5, 32'h0000_A5C3);
        finish_burst(4);

        // Out 8, in 10 inside 12-bit frames; all slots, fastest clock, zero gap
        start_burst(12, 8, 10, 0, 16, 0, 32'h0000_01F3);
        finish_burst(16);

        // R4: all-zero word keeps MOSI at 0
        start_burst(8, 8, 4, 2, 2, 3, 32'h0000_0000);
        finish_burst(2);

        // R9: start while busy is ignored and flagged
        start_burst(16, 16, 16, 3, 3, 2, 32'h0000_3C5A);
        repeat (10) @(negedge clk);
        reg_write(3'd4, 32'h8000_0000);
        chk(reg_rdata[1] == 1'b1, "R9", "collision flag", reg_rdata[1], 1);
        chk(reg_rdata[0] == 1'b1, "R9", "still busy", reg_rdata[0], 1);
        finish_burst(3);
        chk(reg_rdata[1] == 1'b1, "R11", "collision flag sticky", reg_rdata[1], 1);
        start_burst(4, 2, 3, 0, 1, 0, 32'h0000_0002);
        chk(reg_rdata[1] == 1'b0, "R11", "flag cleared by start", reg_rdata[1], 0);
        finish_burst(1);

        // R10: invalid configurations rejected
        begin
            bit cs_moved;
            program_cfg(16, 16, 16, 1, 0, 2, 32'h1);
            reg_write(3'd4, 32'h8000_0000);
            chk(reg_rdata[2:0] == 3'b100, "R10", "zero frame count", reg_rdata[2:0], 3'b100);
            program_cfg(16, 16, 16, 1, MF + 1, 2, 32'h1);
            reg_write(3'd4, 32'h8000_0000);
            chk(reg_rdata[0] == 1'b0, "R10", "count above max not busy", reg_rdata[0], 0);
            program_cfg(8, 9, 4, 1, 2, 2, 32'h1);
            reg_write(3'd4, 32'h8000_0000);
            cs_moved = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!spi_cs_n || reg_rdata[0]) cs_moved = 1;
            end
            chk(!cs_moved, "R10", "out above frame keeps cs high", cs_moved, 0);
            chk(reg_rdata[2] == 1'b1, "R11", "cfg flag sticky", reg_rdata[2], 1);
        end
        start_burst(6, 6, 6, 1, 2, 1, 32'h0000_0015);
        chk(reg_rdata[2] == 1'b0, "R11", "cfg flag cleared", reg_rdata[2], 0);
        finish_burst(2);

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule